// File: doc/BRIEF.md
# Fractional Tick Accumulator

The block turns readings of a free-running 32-bit cycle counter into whole system ticks. A fixed-point scale constant gives ticks per cycle times 2^48, so the upper 16 bits hold the integer part of the rate and the lower 48 bits hold its fraction. When a sample strobe arrives, the block subtracts the previously accepted counter reading from the current one, modulo 2^32. It multiplies that difference by the scale and adds the fraction left over from the last sample. The bits above position 48 are reported as the tick count for that sample. The low 48 bits are kept and carried into the next sample, so truncation never drops ticks over a long run.

The multiply runs over several clock cycles, one chunk of the counter difference per cycle, while a busy flag is raised. An initialise input loads a starting counter value and clears the carried fraction. A strobe that arrives during a computation is dropped and sets a sticky overrun flag. A 32-bit running total adds up every reported tick count. The scale constant is computed outside the block and is presented on an input.

Top module: `fta_accum`

## Requirements
- R1: While reset is high and on the first cycle after it, `valid_o`, `busy_o` and `overrun_o` are 0, and `ticks_o` and `total_o` are 0.
- R2: An accepted strobe uses difference = `count_i` minus the last accepted reading, modulo 2^32, so a counter that wraps past zero gives the true short difference. The strobe's `count_i` then becomes the new last reading.
- R3: The sum S = (difference × scale, truncated to 64 bits) + carried fraction, taken modulo 2^64. `ticks_o` = S[63:48]. S[47:0] is carried into the next sample.
- R4: When `init_i` is high, the last reading is loaded from `init_count_i`, the carried fraction is cleared, and any computation in progress is abandoned without producing a result. A strobe given in the same cycle as `init_i` is ignored.
- R5: A strobe accepted at a clock edge gives a one-cycle `valid_o` pulse exactly 4 edges later (counter width / chunk width). `busy_o` is high from the accepting edge until the result edge, and low while `valid_o` is high.
- R6: A strobe that arrives while `busy_o` is high is ignored. It does not change the result in flight or the last reading, and it sets `overrun_o`, which stays set until reset.
- R7: At each result, `total_o` grows by `ticks_o`, modulo 2^32. It is otherwise unchanged and is cleared only by reset.
- R8: The scale is captured at the accepting edge. Changes on `scale_i` while `busy_o` is high do not affect that result.
- R9: The product keeps only its low 64 bits before the fraction is added. For example, with scale all-ones and difference 3, `ticks_o` is 16'hFFFF and the carried fraction is 48'hFFFF_FFFF_FFFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load starting reading, clear fraction, abort computation |
| init_count_i | input | 32 | Starting counter reading loaded by `init_i` |
| scale_i | input | 64 | Ticks per cycle times 2^48 |
| sample_i | input | 1 | Sample strobe |
| count_i | input | 32 | Current cycle counter reading |
| ticks_o | output | 16 | Whole ticks from the latest result |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| total_o | output | 32 | Running total of ticks |
| busy_o | output | 1 | Computation in progress |
| overrun_o | output | 1 | Sticky flag: a strobe was dropped while busy |

## Verification
The assertions take it for granted that reset is held for at least one edge before any checking begins. They also assume that `init_i` and `sample_i` are sampled only at clock edges. Under those conditions the overrun flag can rise only from a strobe during busy, and results can appear only as isolated pulses. The bench drives every input on the falling edge, so each strobe and init is a clean single-cycle level at the rising edge. It deliberately overlaps strobes with busy, init with busy, and init with a strobe, and it changes the scale in the middle of a computation. This tests the ignore and priority rules against an independent model of the carried fraction.

// File: rtl/fta_pkg.sv
package fta_pkg;
    localparam int CNT_W  = 32;
    localparam int FRAC_W = 48;
    localparam int ACC_W  = 64;
    localparam int TICK_W = ACC_W - FRAC_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ACC_W-1:0]  scale_t;
    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [FRAC_W-1:0] frac_t;

    typedef struct packed {
        tick_t whole;
        frac_t frac;
    } acc_t;

    // one multiply-add step: partial product of a shifted multiplicand and a digit
    function automatic acc_t mac_step(input acc_t acc, input scale_t mcand, input scale_t digit);
        scale_t prod;
        prod = mcand * digit;
        return acc_t'(scale_t'(acc) + prod);
    endfunction
endpackage

// File: rtl/fta_sampler.sv
module fta_sampler
    import fta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  cnt_t init_count_i,
    input  logic sample_i,
    input  cnt_t count_i,
    input  logic busy_i,
    output logic start_o,
    output cnt_t delta_o,
    output logic overrun_o
);
    cnt_t last_q;
    logic ovr_q;

    assign start_o   = sample_i && !busy_i && !init_i;
    assign delta_o   = count_i - last_q;
    assign overrun_o = ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            ovr_q  <= 1'b0;
        end else if (init_i) begin
            last_q <= init_count_i;
        end else begin
            if (start_o)
                last_q <= count_i;
            if (sample_i && busy_i)
                ovr_q <= 1'b1;
        end
    end
endmodule

// File: rtl/fta_mac.sv
module fta_mac
    import fta_pkg::*;
#(
    parameter int CHUNK_W = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   init_i,
    input  logic   start_i,
    input  cnt_t   delta_i,
    input  scale_t scale_i,
    output logic   busy_o,
    output logic   fin_o,
    output acc_t   res_o
);
    localparam int STEPS  = CNT_W / CHUNK_W;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    acc_t              acc_q;
    frac_t             frac_q;
    scale_t            mcand_q;
    cnt_t              mplier_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    acc_t              acc_next;

    assign acc_next = mac_step(acc_q, mcand_q, scale_t'(mplier_q[CHUNK_W-1:0]));
    assign fin_o    = busy_q && (step_q == LAST_STEP) && !init_i;
    assign busy_o   = busy_q;
    assign res_o    = acc_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            frac_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            step_q   <= '0;
            busy_q   <= 1'b0;
        end else if (init_i) begin
            frac_q <= '0;
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (start_i) begin
            acc_q    <= acc_t'({{TICK_W{1'b0}}, frac_q});
            mcand_q  <= scale_i;
            mplier_q <= delta_i;
            step_q   <= '0;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            acc_q    <= acc_next;
            mcand_q  <= mcand_q << CHUNK_W;
            mplier_q <= mplier_q >> CHUNK_W;
            step_q   <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
                frac_q <= acc_next.frac;
            end
        end
    end
endmodule

// File: rtl/fta_total.sv
module fta_total
    import fta_pkg::*;
#(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin_i,
    input  tick_t            ticks_i,
    output tick_t            ticks_o,
    output logic             valid_o,
    output logic [TOT_W-1:0] total_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_o <= '0;
            valid_o <= 1'b0;
            total_o <= '0;
        end else begin
            valid_o <= fin_i;
            if (fin_i) begin
                ticks_o <= ticks_i;
                total_o <= total_o + TOT_W'(ticks_i);
            end
        end
    end
endmodule

// File: rtl/fta_accum.sv
module fta_accum
    import fta_pkg::*;
#(
    parameter int CHUNK_W = 8,
    parameter int TOT_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init_i,
    input  logic [CNT_W-1:0]      init_count_i,
    input  logic [ACC_W-1:0]      scale_i,
    input  logic                  sample_i,
    input  logic [CNT_W-1:0]      count_i,
    output logic [TICK_W-1:0]     ticks_o,
    output logic                  valid_o,
    output logic [TOT_W-1:0]      total_o,
    output logic                  busy_o,
    output logic                  overrun_o
);
    logic start;
    cnt_t delta;
    logic fin;
    acc_t res;

    fta_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .init_i       (init_i),
        .init_count_i (init_count_i),
        .sample_i     (sample_i),
        .count_i      (count_i),
        .busy_i       (busy_o),
        .start_o      (start),
        .delta_o      (delta),
        .overrun_o    (overrun_o)
    );

    fta_mac #(.CHUNK_W(CHUNK_W)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .init_i  (init_i),
        .start_i (start),
        .delta_i (delta),
        .scale_i (scale_i),
        .busy_o  (busy_o),
        .fin_o   (fin),
        .res_o   (res)
    );

    fta_total #(.TOT_W(TOT_W)) u_total (
        .clk     (clk),
        .rst     (rst),
        .fin_i   (fin),
        .ticks_i (res.whole),
        .ticks_o (ticks_o),
        .valid_o (valid_o),
        .total_o (total_o)
    );
endmodule

// File: rtl/fta_accum_chk.sv
module fta_accum_chk #(
    parameter int TOT_W  = 32,
    parameter int TICK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              init_i,
    input logic              sample_i,
    input logic              busy_o,
    input logic              valid_o,
    input logic              overrun_o,
    input logic [TICK_W-1:0] ticks_o,
    input logic [TOT_W-1:0]  total_o
);
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !busy_o);
    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
    // R6
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> $past(sample_i && busy_o && !init_i));
    // R7
    total_add_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> total_o == $past(total_o) + TOT_W'(ticks_o));
    // R7
    total_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> total_o == $past(total_o));
    // R4
    init_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $past(init_i) |-> (!busy_o && !valid_o));
endmodule

bind fta_accum fta_accum_chk #(.TOT_W(TOT_W), .TICK_W(fta_pkg::TICK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_i    (init_i),
    .sample_i  (sample_i),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o),
    .ticks_o   (ticks_o),
    .total_o   (total_o)
);

// File: tb/tb_fta_accum.sv
`timescale 1ns/1ps
module tb_fta_accum;
    localparam int STEPS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_i = 1'b0;
    logic [31:0] init_count_i = '0;
    logic [63:0] scale_i = '0;
    logic        sample_i = 1'b0;
    logic [31:0] count_i = '0;
    logic [15:0] ticks_o;
    logic        valid_o;
    logic [31:0] total_o;
    logic        busy_o;
    logic        overrun_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] m_last = '0;
    logic [47:0] m_frac = '0;
    logic [31:0] m_total = '0;
    logic [15:0] m_ticks = '0;

    localparam logic [95:0] VEC [0:5] = '{
        {32'd1000,       64'h0000_0041_8937_4BC6},
        {32'd2000,       64'h0000_0041_8937_4BC6},
        {32'd2600,       64'h0000_0041_8937_4BC6},
        {32'h0001_0000,  64'h0001_0000_0000_0000},
        {32'h0001_2345,  64'h0000_8000_0000_0001},
        {32'h0001_3345,  64'h0000_0000_0000_0000}
    };

    fta_accum dut (
        .clk(clk), .rst(rst), .init_i(init_i), .init_count_i(init_count_i),
        .scale_i(scale_i), .sample_i(sample_i), .count_i(count_i),
        .ticks_o(ticks_o), .valid_o(valid_o), .total_o(total_o),
        .busy_o(busy_o), .overrun_o(overrun_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] c, input logic [63:0] s);
        logic [31:0] d;
        logic [63:0] acc;
        d = c - m_last;
        m_last = c;
        acc = (64'(d) * s) + {16'h0, m_frac};
        m_ticks = acc[63:48];
        m_frac = acc[47:0];
        m_total = m_total + 32'(m_ticks);
    endtask

    task automatic do_init(input logic [31:0] v);
        @(negedge clk); init_i = 1'b1; init_count_i = v;
        @(negedge clk); init_i = 1'b0;
        m_last = v; m_frac = '0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        while (!valid_o && lat < 20) begin
            @(negedge clk); lat++;
        end
    endtask

    task automatic do_sample(input logic [31:0] c, output int lat);
        @(negedge clk); sample_i = 1'b1; count_i = c;
        @(negedge clk); sample_i = 1'b0;
        wait_valid(lat);
    endtask

    task automatic check_result(input string tag, input int lat);
        chk(lat == STEPS, "R5 latency", 64'(lat), 64'(STEPS));
        chk(ticks_o == m_ticks, tag, 64'(ticks_o), 64'(m_ticks));
        chk(total_o == m_total, "R7 total", 64'(total_o), 64'(m_total));
        @(negedge clk);
        chk(!valid_o && !busy_o, "R5 pulse", {62'd0, valid_o, busy_o}, 64'd0);
    endtask

    task automatic no_result(input string tag);
        bit seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (valid_o) seen = 1;
        end
        chk(!seen && !busy_o, tag, {62'd0, seen, busy_o}, 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(valid_o == 0, "R1 valid", 64'(valid_o), 0);
        chk(busy_o == 0, "R1 busy", 64'(busy_o), 0);
        chk(overrun_o == 0, "R1 overrun", 64'(overrun_o), 0);
        chk(total_o == 0 && ticks_o == 0, "R1 ticks/total", {ticks_o, total_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!valid_o && !busy_o && !overrun_o, "R1 after reset", {valid_o, busy_o, overrun_o}, 0);

        do_init(32'd0);
        // R3 table walk, fraction carried between samples
        for (int i = 0; i < 6; i++) begin
            scale_i = VEC[i][63:0];
            model(VEC[i][95:64], VEC[i][63:0]);
            do_sample(VEC[i][95:64], lat);
            check_result("R3 ticks", lat);
        end

        // R2 wrap past zero
        do_init(32'hFFFF_FF00);
        scale_i = 64'h0001_0000_0000_0000;
        model(32'h0000_0100, scale_i);
        do_sample(32'h0000_0100, lat);
        chk(ticks_o == 16'h0200, "R2 wrap delta", 64'(ticks_o), 64'h200);
        check_result("R2 ticks", lat);

        // R9 truncation of product
        do_init(32'd0);
        scale_i = 64'hFFFF_FFFF_FFFF_FFFF;
        model(32'd3, scale_i);
        do_sample(32'd3, lat);
        chk(ticks_o == 16'hFFFF, "R9 truncated ticks", 64'(ticks_o), 64'hFFFF);
        check_result("R9 ticks", lat);
        model(32'd4, scale_i);
        do_sample(32'd4, lat);
        chk(ticks_o == 16'h0000, "R9 carried fraction", 64'(ticks_o), 64'h0);
        check_result("R9 ticks2", lat);

        // R8 scale change while busy
        do_init(32'd100);
        scale_i = 64'h0002_0000_0000_0000;
        model(32'd150, scale_i);
        @(negedge clk); sample_i = 1'b1; count_i = 32'd150;
        @(negedge clk); sample_i = 1'b0; scale_i = 64'h0009_0000_0000_0000;
        wait_valid(lat);
        check_result("R8 captured scale", lat);
        scale_i = 64'h0002_0000_0000_0000;

        // R6 strobe while busy ignored, overrun sticky
        chk(overrun_o == 0, "R6 pre", 64'(overrun_o), 0);
        model(32'd170, scale_i);
        @(negedge clk); sample_i = 1'b1; count_i = 32'd170;
        @(negedge clk); sample_i = 1'b1; count_i = 32'd900;
        @(negedge clk); sample_i = 1'b0;
        wait_valid(lat);
        lat = lat + 1;
        check_result("R6 in-flight result", lat);
        chk(overrun_o == 1, "R6 overrun set", 64'(overrun_o), 1);
        model(32'd180, scale_i);
        do_sample(32'd180, lat);
        check_result("R6 last kept", lat);
        chk(overrun_o == 1, "R6 sticky", 64'(overrun_o), 1);

        // R4 init aborts computation
        @(negedge clk); sample_i = 1'b1; count_i = 32'd5000;
        @(negedge clk); sample_i = 1'b0;
        @(negedge clk); init_i = 1'b1; init_count_i = 32'd7000;
        @(negedge clk); init_i = 1'b0;
        m_last = 32'd7000; m_frac = '0;
        no_result("R4 abort");
        scale_i = 64'h0000_4000_0000_0000;
        model(32'd7003, scale_i);
        do_sample(32'd7003, lat);
        check_result("R4 reload", lat);

        // R4 strobe alongside init ignored
        @(negedge clk); init_i = 1'b1; sample_i = 1'b1; init_count_i = 32'd40; count_i = 32'd99;
        @(negedge clk); init_i = 1'b0; sample_i = 1'b0;
        m_last = 32'd40; m_frac = '0;
        no_result("R4 strobe with init");
        model(32'd44, scale_i);
        do_sample(32'd44, lat);
        check_result("R4 init priority", lat);

        // R7 reset clears total
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(total_o == 0, "R7 reset clear", 64'(total_o), 0);
        chk(overrun_o == 0, "R1 overrun clear", 64'(overrun_o), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule